// File: doc/BRIEF.md
# Mode-Banked Processor Status Register

This unit holds a 32-bit processor status word that is built from four 8-bit fields. A move-to-status write replaces only the fields picked by a four-bit select mask. The new value comes from an 8-bit immediate, which is zero-extended, or from a full 32-bit register value. The five low bits of the word name the current operating mode. Bits 7 and 6 are the interrupt mask bits for IRQ and FIQ.

Each of the six privileged modes has its own stack pointer. Startup code can switch to a mode, load that mode's stack pointer, then switch to the next mode and repeat. Every bank keeps its own value. The stack pointer output always shows the bank of the current mode.

Every write is a single-cycle strobe. No write is ever back-pressured, so the block has no ready signals, and a strobe that is high at a rising edge always takes effect. A status write changes `psr_q` on that edge. A stack-pointer write becomes visible on `sp_active` on the same edge if the mode is unchanged.

Top module: `mode_bank_status`

## Requirements
- R1: After reset the status word is 0x000000D3, which is supervisor mode with both interrupt masks set. `mode_valid` is 1 and every stack-pointer bank holds 0.
- R2: The mask bits map to byte fields as follows: bit 0 selects bits 7:0, bit 1 selects bits 15:8, bit 2 selects bits 23:16 and bit 3 selects bits 31:24. Bytes that are not selected keep their value.
- R3: When `psr_src_is_imm` is 1, the source is `{24'h0, psr_imm}`. A selected upper field is therefore written with 0.
- R4: A write may select any combination of fields. A mask of 4'b0000 leaves the word unchanged.
- R5: `irq_masked` equals bit 7 of the status word and `fiq_masked` equals bit 6.
- R6: The valid mode codes in bits 4:0 are 0x11 FIQ, 0x12 IRQ, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. Each of these codes sets `mode_valid` to 1.
- R7: A stack-pointer write updates only the bank of the current mode. `sp_active` shows the bank of the current mode, and the other banks keep their values.
- R8: Any other mode code sets `mode_valid` to 0. Stack-pointer reads and writes then use the system-mode bank.
- R9: If a status write and a stack-pointer write happen in the same cycle, the stack-pointer write uses the mode from before the status update.
- R10: The status word changes only on a cycle where `psr_wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psr_wr_en | input | 1 | Status write strobe |
| psr_field_mask | input | 4 | Field select for the status write |
| psr_src_is_imm | input | 1 | 1: source is the immediate, 0: source is the register value |
| psr_imm | input | 8 | Immediate source |
| psr_reg | input | 32 | Register source |
| sp_wr_en | input | 1 | Stack-pointer write strobe |
| sp_wr_data | input | 32 | Stack-pointer write value |
| psr_q | output | 32 | Current status word |
| sp_active | output | 32 | Stack pointer of the current mode |
| irq_masked | output | 1 | IRQ disabled |
| fiq_masked | output | 1 | FIQ disabled |
| mode_valid | output | 1 | Mode field holds a listed code |

## Verification
The hardest case to reach from the ports is a status write and a stack-pointer write in the same cycle. The stimulus first loads a marker into the target mode's bank. It then switches mode while writing a new stack pointer in that same cycle. After that it switches between modes to check that the old mode's bank took the value and the new mode's bank kept its marker. Invalid mode codes are reached through an immediate write to all fields, which makes the aliasing onto the system bank visible.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int XLEN      = 32;
  localparam int FIELD_W   = 8;
  localparam int NFIELDS   = XLEN / FIELD_W;
  localparam int MODE_W    = 5;
  localparam int NBANKS    = 6;
  localparam int BANK_IDX_W = $clog2(NBANKS);

  typedef enum logic [MODE_W-1:0] {
    MODE_FIQ = 5'h11,
    MODE_IRQ = 5'h12,
    MODE_SVC = 5'h13,
    MODE_ABT = 5'h17,
    MODE_UND = 5'h1B,
    MODE_SYS = 5'h1F
  } cpu_mode_e;

  typedef logic [BANK_IDX_W-1:0] bank_idx_t;

  localparam bank_idx_t BANK_FIQ = 3'd0;
  localparam bank_idx_t BANK_IRQ = 3'd1;
  localparam bank_idx_t BANK_SVC = 3'd2;
  localparam bank_idx_t BANK_ABT = 3'd3;
  localparam bank_idx_t BANK_UND = 3'd4;
  localparam bank_idx_t BANK_SYS = 3'd5;

  localparam int IRQ_BIT = 7;
  localparam int FIQ_BIT = 6;
endpackage

// File: rtl/psr_field_merge.sv
module psr_field_merge
  import msr_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int NF = NFIELDS,
  parameter int IW = 8,
  localparam int W = FW * NF
) (
  input  logic [W-1:0]  cur_word,
  input  logic [NF-1:0] field_sel,
  input  logic          use_imm,
  input  logic [IW-1:0] imm_val,
  input  logic [W-1:0]  reg_val,
  output logic [W-1:0]  next_word
);
  logic [W-1:0] src_word;

  always_comb begin
    if (use_imm) src_word = {{(W-IW){1'b0}}, imm_val};
    else         src_word = reg_val;
  end

  for (genvar f = 0; f < NF; f++) begin : g_field
    assign next_word[f*FW +: FW] = field_sel[f] ? src_word[f*FW +: FW]
                                                : cur_word[f*FW +: FW];
  end
endmodule

// File: rtl/mode_decoder.sv
module mode_decoder
  import msr_pkg::*;
(
  input  logic [MODE_W-1:0] mode_bits,
  output bank_idx_t         bank_sel,
  output logic              known
);
  always_comb begin
    known    = 1'b1;
    bank_sel = BANK_SYS;
    case (mode_bits)
      MODE_FIQ: bank_sel = BANK_FIQ;
      MODE_IRQ: bank_sel = BANK_IRQ;
      MODE_SVC: bank_sel = BANK_SVC;
      MODE_ABT: bank_sel = BANK_ABT;
      MODE_UND: bank_sel = BANK_UND;
      MODE_SYS: bank_sel = BANK_SYS;
      default: begin
        known    = 1'b0;
        bank_sel = BANK_SYS;
      end
    endcase
  end
endmodule

// File: rtl/sp_bank_file.sv
module sp_bank_file
  import msr_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int NB = NBANKS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  bank_idx_t       sel,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data
);
  logic [DW-1:0] bank_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    bank_q[b] <= '0;
      else if (wr_en && (sel == bank_idx_t'(b)))     bank_q[b] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NB; b++) begin
      if (sel == bank_idx_t'(b)) rd_data = bank_q[b];
    end
  end
endmodule

// File: rtl/mode_bank_status.sv
module mode_bank_status
  import msr_pkg::*;
#(
  parameter logic [31:0] RESET_WORD = 32'h0000_00D3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psr_wr_en,
  input  logic [3:0]  psr_field_mask,
  input  logic        psr_src_is_imm,
  input  logic [7:0]  psr_imm,
  input  logic [31:0] psr_reg,
  input  logic        sp_wr_en,
  input  logic [31:0] sp_wr_data,
  output logic [31:0] psr_q,
  output logic [31:0] sp_active,
  output logic        irq_masked,
  output logic        fiq_masked,
  output logic        mode_valid
);
  logic [XLEN-1:0] word_q;
  logic [XLEN-1:0] word_next;
  bank_idx_t       cur_bank;
  logic            cur_known;

  psr_field_merge #(.FW(FIELD_W), .NF(NFIELDS), .IW(8)) u_merge (
    .cur_word  (word_q),
    .field_sel (psr_field_mask),
    .use_imm   (psr_src_is_imm),
    .imm_val   (psr_imm),
    .reg_val   (psr_reg),
    .next_word (word_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_q <= RESET_WORD;
    else if (psr_wr_en) word_q <= word_next;
  end

  // Decode uses the registered word, so a same-cycle SP write sees the old mode.
  mode_decoder u_dec (
    .mode_bits (word_q[MODE_W-1:0]),
    .bank_sel  (cur_bank),
    .known     (cur_known)
  );

  sp_bank_file #(.DW(XLEN), .NB(NBANKS)) u_banks (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sp_wr_en),
    .sel     (cur_bank),
    .wr_data (sp_wr_data),
    .rd_data (sp_active)
  );

  assign psr_q      = word_q;
  assign irq_masked = word_q[IRQ_BIT];
  assign fiq_masked = word_q[FIQ_BIT];
  assign mode_valid = cur_known;
endmodule

// File: rtl/mode_bank_status_chk.sv
module mode_bank_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        psr_wr_en,
  input logic [3:0]  psr_field_mask,
  input logic        psr_src_is_imm,
  input logic        sp_wr_en,
  input logic [31:0] sp_wr_data,
  input logic [31:0] psr_q,
  input logic [31:0] sp_active
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R10
  psr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(psr_wr_en)) |-> (psr_q == $past(psr_q)));

  // R2
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(psr_wr_en) && !$past(psr_field_mask[0]))
      |-> (psr_q[7:0] == $past(psr_q[7:0])));

  // R3
  imm_zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(psr_wr_en) && $past(psr_src_is_imm) && $past(psr_field_mask[3]))
      |-> (psr_q[31:24] == 8'h00));

  // R7
  sp_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(sp_wr_en) && (psr_q[4:0] == $past(psr_q[4:0])))
      |-> (sp_active == $past(sp_wr_data)));

  // R7
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(sp_wr_en) && !$past(psr_wr_en)) |-> $stable(sp_active));
endmodule

bind mode_bank_status mode_bank_status_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .psr_wr_en      (psr_wr_en),
  .psr_field_mask (psr_field_mask),
  .psr_src_is_imm (psr_src_is_imm),
  .sp_wr_en       (sp_wr_en),
  .sp_wr_data     (sp_wr_data),
  .psr_q          (psr_q),
  .sp_active      (sp_active)
);

// File: tb/mode_bank_status_tb.sv
module mode_bank_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psr_wr_en = 1'b0;
  logic [3:0]  psr_field_mask = '0;
  logic        psr_src_is_imm = 1'b0;
  logic [7:0]  psr_imm = '0;
  logic [31:0] psr_reg = '0;
  logic        sp_wr_en = 1'b0;
  logic [31:0] sp_wr_data = '0;
  logic [31:0] psr_q, sp_active;
  logic        irq_masked, fiq_masked, mode_valid;

  always #2.5 clk = ~clk;

  mode_bank_status u_dut (.*);

  typedef struct {
    logic [31:0] psr;
    logic [31:0] sp;
    logic        valid;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  logic [31:0] m_psr;
  logic [31:0] m_sp [6];
  bit done = 0;

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      5'h17: return 3;
      5'h1B: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic bit known(input logic [4:0] m);
    return (m == 5'h11 || m == 5'h12 || m == 5'h13 || m == 5'h17 ||
            m == 5'h1B || m == 5'h1F);
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    e.psr = m_psr; e.sp = m_sp[bank_of(m_psr[4:0])];
    e.valid = known(m_psr[4:0]); e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Driver: one cycle of stimulus, model update, expected item queued.
  task automatic step(input bit pw, input logic [3:0] msk, input bit imm,
                      input logic [7:0] iv, input logic [31:0] rv,
                      input bit sw, input logic [31:0] sd, input string tag);
    logic [31:0] src;
    @(negedge clk);
    psr_wr_en = pw; psr_field_mask = msk; psr_src_is_imm = imm;
    psr_imm = iv; psr_reg = rv; sp_wr_en = sw; sp_wr_data = sd;
    @(posedge clk);
    #1;
    src = imm ? {24'h0, iv} : rv;
    if (sw) m_sp[bank_of(m_psr[4:0])] = sd;
    if (pw) for (int f = 0; f < 4; f++)
      if (msk[f]) m_psr[f*8 +: 8] = src[f*8 +: 8];
    push_exp(tag);
  endtask

  task automatic set_ctrl(input logic [7:0] v, input string tag);
    step(1, 4'b0001, 1, v, 32'h0, 0, 32'h0, tag);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (psr_q !== e.psr || sp_active !== e.sp || mode_valid !== e.valid ||
          irq_masked !== e.psr[7] || fiq_masked !== e.psr[6]) begin
        fails++;
        $display("FAIL %s: psr=%h sp=%h valid=%b irq=%b fiq=%b expected psr=%h sp=%h valid=%b irq=%b fiq=%b",
                 e.tag, psr_q, sp_active, mode_valid, irq_masked, fiq_masked,
                 e.psr, e.sp, e.valid, e.psr[7], e.psr[6]);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [6];
    modes = '{5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
    m_psr = 32'h0000_00D3;
    for (int b = 0; b < 6; b++) m_sp[b] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(0, 4'b0, 0, 8'h0, 32'h0, 0, 32'h0, "R1 reset");
    // R6 / R7: visit every mode and load its stack pointer
    for (int i = 0; i < 6; i++) begin
      set_ctrl({3'b110, modes[i]}, "R6 mode select");
      step(0, 4'b0, 0, 8'h0, 32'h0, 1, 32'h1000_0000 + 32'(i) * 32'h100, "R7 sp load");
    end
    // R7: banks retained on revisit
    for (int i = 0; i < 6; i++) set_ctrl({3'b110, modes[i]}, "R7 bank retained");
    // R2: flags field from register source
    step(1, 4'b1000, 0, 8'hFF, 32'hA5C3_3C5A, 0, 32'h0, "R2 flags field only");
    // R4: two middle fields
    step(1, 4'b0110, 0, 8'h00, 32'h1234_5678, 0, 32'h0, "R4 ext+status fields");
    // R4: empty mask
    step(1, 4'b0000, 0, 8'h00, 32'hFFFF_FFFF, 0, 32'h0, "R4 empty mask");
    // R10: data present, no strobe
    step(0, 4'b1111, 0, 8'h00, 32'h0000_0000, 0, 32'h0, "R10 no strobe");
    // R5: clear both masks in supervisor, then set IRQ only
    set_ctrl(8'h13, "R5 masks cleared");
    set_ctrl(8'h93, "R5 irq masked only");
    set_ctrl(8'h53, "R5 fiq masked only");
    // R3 / R8: immediate to all fields, invalid mode 0x1A
    step(1, 4'b1111, 1, 8'h5A, 32'hFFFF_FFFF, 0, 32'h0, "R3 R8 imm zero-extend, invalid mode");
    step(0, 4'b0, 0, 8'h0, 32'h0, 1, 32'hDEAD_0001, "R8 sp write aliases system bank");
    set_ctrl(8'hDF, "R8 system bank holds aliased write");
    set_ctrl(8'h10, "R8 code 0x10 invalid");
    // R9: same-cycle mode change and SP write
    set_ctrl(8'hD2, "R9 enter IRQ");
    step(0, 4'b0, 0, 8'h0, 32'h0, 1, 32'h0000_1111, "R9 irq marker");
    set_ctrl(8'hD3, "R9 enter SVC");
    step(1, 4'b0001, 1, 8'hD2, 32'h0, 1, 32'h0000_2222, "R9 switch with sp write");
    set_ctrl(8'hD3, "R9 old mode bank took write");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule